// File: doc/BRIEF.md
# Line Switch State Controller

This block is a synchronous controller for a small bank of line-access switch enables. A mode code picks which switch is closed, or picks none. An input latch can freeze that code. A three-level shutdown control sits outside the latch and can force every switch open or mask the thermal-fault flag. A battery monitor with hysteresis watches a signed millivolt sample and a battery-present flag. The highest-numbered enable belongs to the ringing switch. When that switch is commanded open, it stays closed until the next current zero-crossing strobe.

Every output is registered, so a change at the inputs shows up one clock later. There is one exception: while a ringing turn-off is waiting, the ringing enable waits for the strobe. Force-off, a battery fault and an unmasked thermal fault win over everything else, including a pending ringing turn-off. Any of them clears every enable on the next edge.

Top module: `line_switch_ctrl`

## Requirements
- R1: After reset, `sw_en` is all zeros, `ring_pend` is 0 and `all_off` is 1. The battery monitor starts in the fault state and stays there until it sees a sample below the turn-on limit.
- R2: Mode code k, for 1 <= k <= N_SW, closes only switch bit k-1. Code 0 and every code above N_SW open all switches. Outputs follow one clock after the inputs.
- R3: While `latch_en` is 0, `mode_sel` passes straight through. While `latch_en` is 1, the code captured on the last clock with `latch_en` = 0 is used, and `mode_sel` changes have no effect.
- R4: `sd_ctl` = 2'b00 (force-off) clears all enables on the next clock, whatever the latched mode and even during a pending ringing turn-off. The code 2'b11 acts the same way. `sd_ctl` is never latched.
- R5: With `sd_ctl` = 2'b01 (released), `therm_fault` = 1 clears all enables. With `sd_ctl` = 2'b10 (thermal-disable), `therm_fault` is ignored and the mode code keeps control.
- R6: The ringing switch is bit N_SW-1, selected by code N_SW. When a command drops it, its enable stays at 1 and `ring_pend` is 1 until the clock after a one-cycle `zero_cross` pulse. On that clock the enable goes to 0 and `ring_pend` clears.
- R7: If no `zero_cross` pulse arrives, the ringing enable stays on for as long as the mode code keeps it off. Other switch bits follow the mode code in the meantime.
- R8: `batt_present` = 0 clears all enables on the next clock. They stay cleared until the battery is present again and a sample below the turn-on limit is seen.
- R9: A sample above BATT_OFF_MV (default -10000) puts the block in all-off. Only a sample below BATT_ON_MV (default -15000) leaves it. Samples from -15000 to -10000 inclusive keep the current battery state.
- R10: `all_off` is 1 exactly when every bit of `sw_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | MODE_W | Mode code |
| latch_en | input | 1 | 1 holds the captured mode code |
| sd_ctl | input | 2 | Shutdown control: 00 force-off, 01 released, 10 thermal-disable, 11 force-off |
| therm_fault | input | 1 | Thermal fault flag |
| zero_cross | input | 1 | Synchronised one-cycle ringing-current zero-crossing pulse |
| batt_present | input | 1 | Battery voltage present |
| batt_mv | input | BATT_W | Signed battery sample in millivolts |
| sw_en | output | N_SW | Switch enables, ringing switch in the top bit |
| ring_pend | output | 1 | Ringing turn-off waiting for a zero-crossing |
| all_off | output | 1 | No switch enabled |

## Verification
The assertions assume that `zero_cross` is already synchronous and lasts one cycle. They also assume that `batt_mv` is a valid signed sample on every cycle where `batt_present` is 1. The bench changes every input only on the falling edge and drives `zero_cross` high for exactly one cycle. It uses battery samples that fit in BATT_W bits, including values exactly on both limits. It reads results on the following falling edge, one register stage after the stimulus.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    typedef enum logic [1:0] {
        SD_FORCE   = 2'b00,
        SD_RELEASE = 2'b01,
        SD_THDIS   = 2'b10,
        SD_RSVD    = 2'b11
    } sd_mode_e;

    function automatic logic sd_forces_off(input logic [1:0] code);
        return (code == SD_FORCE) || (code == SD_RSVD);
    endfunction

    function automatic logic sd_masks_thermal(input logic [1:0] code);
        return code == SD_THDIS;
    endfunction

endpackage

// File: rtl/lsc_mode_stage.sv
module lsc_mode_stage #(
    parameter int MODE_W = 3,
    parameter int N_SW   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              latch_en,
    output logic [N_SW-1:0]   tgt_pat
);
    typedef struct packed {
        logic [MODE_W-1:0] mode;
    } stage_t;

    stage_t st_d, st_q;
    logic [MODE_W-1:0] eff_mode;

    always_comb begin
        st_d = st_q;
        if (!latch_en) st_d.mode = mode_sel;
        eff_mode = latch_en ? st_q.mode : mode_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < N_SW; i++) begin : g_dec
        assign tgt_pat[i] = (eff_mode == MODE_W'(i + 1));
    end

    // R3: captured code is frozen while the latch is held
    assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        latch_en |=> st_q.mode == $past(st_q.mode));

endmodule

// File: rtl/lsc_batt_mon.sv
module lsc_batt_mon #(
    parameter int BATT_W      = 16,
    parameter int BATT_OFF_MV = -10000,
    parameter int BATT_ON_MV  = -15000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     batt_present,
    input  logic signed [BATT_W-1:0] batt_mv,
    output logic                     ok_d,
    output logic                     ok_q
);
    localparam logic signed [BATT_W-1:0] OFF_LIM = BATT_OFF_MV[BATT_W-1:0];
    localparam logic signed [BATT_W-1:0] ON_LIM  = BATT_ON_MV[BATT_W-1:0];

    typedef struct packed {
        logic ok;
    } mon_t;

    mon_t m_d, m_q;
    logic too_high, low_enough;

    always_comb begin
        too_high   = batt_mv > OFF_LIM;
        low_enough = batt_mv < ON_LIM;
        m_d = m_q;
        if (!batt_present || too_high) m_d.ok = 1'b0;
        else if (low_enough)           m_d.ok = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign ok_d = m_d.ok;
    assign ok_q = m_q.ok;

    // R9: between the limits the state is kept
    assert_hyst_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (batt_present && batt_mv <= OFF_LIM && batt_mv >= ON_LIM) |=> ok_q == $past(ok_q));

    // R9: a sample above the upper limit always faults
    assert_high_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (batt_present && batt_mv > OFF_LIM) |=> !ok_q);

    // R8: no battery means a fault
    assert_loss_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !batt_present |=> !ok_q);

endmodule

// File: rtl/line_switch_ctrl.sv
module line_switch_ctrl
    import lsc_pkg::*;
#(
    parameter int MODE_W      = 3,
    parameter int N_SW        = 4,
    parameter int BATT_W      = 16,
    parameter int BATT_OFF_MV = -10000,
    parameter int BATT_ON_MV  = -15000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [MODE_W-1:0]        mode_sel,
    input  logic                     latch_en,
    input  logic [1:0]               sd_ctl,
    input  logic                     therm_fault,
    input  logic                     zero_cross,
    input  logic                     batt_present,
    input  logic signed [BATT_W-1:0] batt_mv,
    output logic [N_SW-1:0]          sw_en,
    output logic                     ring_pend,
    output logic                     all_off
);
    localparam int RING = N_SW - 1;

    typedef struct packed {
        logic [N_SW-1:0] sw_en;
        logic            ring_pend;
        logic            all_off;
    } ctl_t;

    ctl_t c_d, c_q;
    logic [N_SW-1:0] tgt_pat;
    logic batt_ok_d, batt_ok_q;
    logic force_off, therm_mask, kill;

    lsc_mode_stage #(.MODE_W(MODE_W), .N_SW(N_SW)) u_stage (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .latch_en(latch_en), .tgt_pat(tgt_pat)
    );

    lsc_batt_mon #(.BATT_W(BATT_W), .BATT_OFF_MV(BATT_OFF_MV), .BATT_ON_MV(BATT_ON_MV)) u_batt (
        .clk(clk), .rst_n(rst_n), .batt_present(batt_present),
        .batt_mv(batt_mv), .ok_d(batt_ok_d), .ok_q(batt_ok_q)
    );

    always_comb begin
        force_off  = sd_forces_off(sd_ctl);
        therm_mask = sd_masks_thermal(sd_ctl);
        kill       = force_off | ~batt_ok_d | (therm_fault & ~therm_mask);

        c_d = c_q;
        c_d.sw_en = tgt_pat;
        if (c_q.sw_en[RING] && !tgt_pat[RING] && !zero_cross)
            c_d.sw_en[RING] = 1'b1;
        if (kill)
            c_d.sw_en = '0;
        c_d.ring_pend = c_d.sw_en[RING] & ~tgt_pat[RING];
        c_d.all_off   = ~|c_d.sw_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.sw_en     <= '0;
            c_q.ring_pend <= 1'b0;
            c_q.all_off   <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign sw_en     = c_q.sw_en;
    assign ring_pend = c_q.ring_pend;
    assign all_off   = c_q.all_off;

    // R4: shutdown force-off wins over everything
    assert_force_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_ctl == SD_FORCE || sd_ctl == SD_RSVD) |=> sw_en == '0);

    // R8: battery loss opens every switch
    assert_batt_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !batt_present |=> sw_en == '0);

    // R5: unmasked thermal fault opens every switch
    assert_therm_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_ctl == SD_RELEASE && therm_fault) |=> sw_en == '0);

    // R7: ringing switch held on until a zero-crossing unless killed
    assert_ring_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en[RING] && !zero_cross && batt_ok_d &&
         (sd_ctl == SD_THDIS || (sd_ctl == SD_RELEASE && !therm_fault))) |=> sw_en[RING]);

    // R6: zero-crossing releases a dropped ringing switch
    assert_ring_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en[RING] && zero_cross && !tgt_pat[RING]) |=> !sw_en[RING] && !ring_pend);

    // R2: outside a pending ringing release at most one switch is closed
    assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ring_pend |-> $onehot0(sw_en));

    // R10: status agrees with the enables
    assert_all_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        all_off == (sw_en == '0));

endmodule

// File: tb/line_switch_ctrl_bench.sv
module line_switch_ctrl_bench;
    localparam int MODE_W = 3;
    localparam int N_SW   = 4;
    localparam int BATT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [MODE_W-1:0] mode_sel = '0;
    logic latch_en = 1'b0;
    logic [1:0] sd_ctl = 2'b01;
    logic therm_fault = 1'b0;
    logic zero_cross = 1'b0;
    logic batt_present = 1'b1;
    logic signed [BATT_W-1:0] batt_mv = -16'sd16000;
    logic [N_SW-1:0] sw_en;
    logic ring_pend, all_off;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    line_switch_ctrl #(.MODE_W(MODE_W), .N_SW(N_SW), .BATT_W(BATT_W)) u_line_switch_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .latch_en(latch_en),
        .sd_ctl(sd_ctl), .therm_fault(therm_fault), .zero_cross(zero_cross),
        .batt_present(batt_present), .batt_mv(batt_mv),
        .sw_en(sw_en), .ring_pend(ring_pend), .all_off(all_off)
    );

    function automatic logic [N_SW-1:0] pat(input int code);
        return (code >= 1 && code <= N_SW) ? N_SW'(1) << (code - 1) : '0;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp_v);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic go_normal();
        sd_ctl = 2'b01; therm_fault = 0; batt_present = 1; batt_mv = -16'sd16000;
        latch_en = 0; mode_sel = 0; zero_cross = 0;
        step(2);
    endtask

    task automatic t_reset();
        chk("R1 sw_en", 8'(sw_en), 8'h0);
        chk("R1 ring_pend", 8'(ring_pend), 8'h0);
        chk("R1 all_off", 8'(all_off), 8'h1);
        batt_mv = -16'sd12000; mode_sel = 3'd1;
        rst_n = 1'b1;
        step(3);
        chk("R1 battery starts faulted", 8'(sw_en), 8'h0);
        batt_mv = -16'sd16000;
        step(1);
        chk("R1 valid sample releases", 8'(sw_en), 8'(pat(1)));
    endtask

    task automatic t_decode();
        go_normal();
        for (int c = 0; c < 8; c++) begin
            mode_sel = 3'(c);
            step(1);
            if (c == N_SW + 1) begin
                zero_cross = 1; step(1); zero_cross = 0;
            end
            chk("R2 decode", 8'(sw_en), 8'(pat(c)));
            chk("R10 all_off", 8'(all_off), 8'(pat(c) == 0));
        end
    endtask

    task automatic t_latch();
        go_normal();
        mode_sel = 3'd2; step(1);
        latch_en = 1; mode_sel = 3'd3; step(1);
        chk("R3 latched holds", 8'(sw_en), 8'(pat(2)));
        mode_sel = 3'd1; step(2);
        chk("R3 input ignored", 8'(sw_en), 8'(pat(2)));
        latch_en = 0; step(1);
        chk("R3 transparent", 8'(sw_en), 8'(pat(1)));
    endtask

    task automatic t_force();
        go_normal();
        mode_sel = 3'd2; step(1);
        latch_en = 1; sd_ctl = 2'b00; step(1);
        chk("R4 force-off", 8'(sw_en), 8'h0);
        chk("R10 all_off on force", 8'(all_off), 8'h1);
        sd_ctl = 2'b01; step(1);
        chk("R4 release restores latched", 8'(sw_en), 8'(pat(2)));
        sd_ctl = 2'b11; step(1);
        chk("R4 code 11 forces off", 8'(sw_en), 8'h0);
        latch_en = 0; sd_ctl = 2'b01; mode_sel = 3'd4; step(1);
        mode_sel = 3'd1; step(1);
        chk("R4 pend set", 8'(ring_pend), 8'h1);
        sd_ctl = 2'b00; step(1);
        chk("R4 beats pending ring", 8'(sw_en), 8'h0);
        chk("R4 pend cleared", 8'(ring_pend), 8'h0);
    endtask

    task automatic t_thermal();
        go_normal();
        mode_sel = 3'd3; therm_fault = 1; step(1);
        chk("R5 released thermal trip", 8'(sw_en), 8'h0);
        sd_ctl = 2'b10; step(1);
        chk("R5 masked thermal", 8'(sw_en), 8'(pat(3)));
        sd_ctl = 2'b01; step(1);
        chk("R5 rearmed", 8'(sw_en), 8'h0);
        therm_fault = 0; step(1);
        chk("R5 fault gone", 8'(sw_en), 8'(pat(3)));
    endtask

    task automatic t_ring();
        go_normal();
        mode_sel = 3'd4; step(1);
        chk("R6 ring on", 8'(sw_en), 8'(pat(4)));
        mode_sel = 3'd2; step(1);
        chk("R6 deferred", 8'(sw_en), 8'(pat(4) | pat(2)));
        chk("R6 pending", 8'(ring_pend), 8'h1);
        step(3);
        chk("R6 still held", 8'(sw_en), 8'(pat(4) | pat(2)));
        zero_cross = 1; step(1); zero_cross = 0;
        chk("R6 released at zero-cross", 8'(sw_en), 8'(pat(2)));
        chk("R6 pend clear", 8'(ring_pend), 8'h0);
    endtask

    task automatic t_ring_dc();
        go_normal();
        mode_sel = 3'd4; step(1);
        mode_sel = 3'd0; step(200);
        chk("R7 DC stays on", 8'(sw_en), 8'(pat(4)));
        mode_sel = 3'd1; step(1);
        chk("R7 others follow", 8'(sw_en), 8'(pat(4) | pat(1)));
        mode_sel = 3'd4; step(1);
        chk("R7 reselect", 8'(ring_pend), 8'h0);
        mode_sel = 3'd0; zero_cross = 1; step(1); zero_cross = 0;
        chk("R7 zero-cross ends", 8'(sw_en), 8'h0);
    endtask

    task automatic t_batt();
        go_normal();
        mode_sel = 3'd1; step(1);
        batt_present = 0; step(1);
        chk("R8 loss", 8'(sw_en), 8'h0);
        batt_present = 1; batt_mv = -16'sd12000; step(2);
        chk("R8 held until valid", 8'(sw_en), 8'h0);
        batt_mv = -16'sd16000; step(1);
        chk("R8 restored", 8'(sw_en), 8'(pat(1)));
    endtask

    task automatic t_hyst();
        go_normal();
        mode_sel = 3'd2; step(1);
        batt_mv = -16'sd12000; step(1);
        chk("R9 in band stays on", 8'(sw_en), 8'(pat(2)));
        batt_mv = -16'sd10000; step(1);
        chk("R9 at upper limit holds", 8'(sw_en), 8'(pat(2)));
        batt_mv = -16'sd9999; step(1);
        chk("R9 above limit off", 8'(sw_en), 8'h0);
        batt_mv = -16'sd12000; step(1);
        chk("R9 in band stays off", 8'(sw_en), 8'h0);
        batt_mv = -16'sd15000; step(1);
        chk("R9 at lower limit holds off", 8'(sw_en), 8'h0);
        batt_mv = -16'sd15001; step(1);
        chk("R9 below limit on", 8'(sw_en), 8'(pat(2)));
    endtask

    initial begin
        step(2);
        t_reset();
        t_decode();
        t_latch();
        t_force();
        t_thermal();
        t_ring();
        t_ring_dc();
        t_batt();
        t_hyst();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule